// File: doc/BRIEF.md
# Couplet-Encoded Daisy-Chain Byte Serializer

This block sends one payload byte at a time on a two-wire differential daisy-chain link. An upstream source offers a byte, a start-of-frame flag and a byte-error flag on a valid/ready handshake. Once the block accepts them, it plays a fixed-length symbol on the positive and negative legs. The symbol is built from an opening half-bit, two sync bits, the start-of-frame flag, the eight data bits, the error flag and a closing half-bit.

Every logical bit is sent as a couplet: the bit value for one pulse, then its inverse for one pulse. Each bit therefore spends equal time high and low, and the line carries no DC content. Pulses are timed by a clock-enable divider derived from the system clock frequency. With the defaults, one 250 ns pulse lasts 8 cycles at 32 MHz. The symbol always occupies the same time on the wire. Between symbols, a programmable number of extra idle pulses can be added, which lets a system widen the gap on links that ring.

Top module: `cplt_ser`

## Requirements
- R1: While reset is asserted, and directly after it, both legs are low and `inReady` is high.
- R2: A byte is taken on a rising edge where `inValid` and `inReady` are both high. `inReady` is low from the next cycle until the gap ends. Values on `inValid`, `inData`, `inSof`, `inBerr` and `gapCfg` while `inReady` is low have no effect on the line.
- R3: The first pulse begins on the cycle after acceptance and drives `txPos` high and `txNeg` low.
- R4: Every pulse lasts exactly CLK_HZ/PULSE_HZ clock cycles, which is 8 with the defaults (250 ns at 32 MHz).
- R5: After the opening pulse, twelve couplets follow in this order: sync 0, sync 0, the start-of-frame flag, `inData[0]` through `inData[7]`, and the error flag.
- R6: In each couplet, the first pulse drives `txPos` to the bit and `txNeg` to its inverse, and the second pulse drives them inverted.
- R7: After the last couplet, one pulse drives `txPos` low and `txNeg` high. Both legs are low after that pulse.
- R8: A symbol always lasts 26 pulses, whatever the data and flags.
- R9: `inReady` returns high `gapCfg` idle pulses after the closing pulse ends. If `gapCfg` is 0, it returns high right after the closing pulse. The gap value used is the one sampled at acceptance.
- R10: `txPos` and `txNeg` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte offered |
| inReady | output | 1 | Block can take a byte |
| inData | input | DATA_W | Payload byte, sent LSB first |
| inSof | input | 1 | Start-of-frame flag for this byte |
| inBerr | input | 1 | Byte-error flag for this byte |
| gapCfg | input | GAP_W | Extra idle pulses after the symbol |
| txPos | output | 1 | Positive leg of the link |
| txNeg | output | 1 | Negative leg of the link |

## Verification
Several properties are checked on every cycle: the two legs never rise together, the line is idle whenever the block is ready, an acceptance is followed at once by the opening pulse with ready dropped, and ready only falls after an offered byte. The following can only be shown by the bench's scenarios, which compare the legs cycle by cycle against a model of the whole symbol:
- the bit order inside a symbol and the true-then-inverse couplet shape;
- the exact pulse width;
- the length of the gap;
- the fact that a gap value or byte offered during a symbol is ignored.

// File: rtl/cplt_pkg.sv
package cplt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_GAP
  } cpltState_t;

  // Strobes from control to datapath; at most one emit strobe per cycle.
  typedef struct packed {
    logic load;       // capture byte and flags into the frame register
    logic emitPre;    // opening half-bit
    logic emitTrue;   // first half of a couplet
    logic emitCompl;  // second half of a couplet, then shift
    logic emitPost;   // closing half-bit
    logic emitIdle;   // both legs low
  } cpltStrobe_t;

endpackage

// File: rtl/cplt_ctrl.sv
module cplt_ctrl
  import cplt_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int GAP_W  = 8,
  parameter int NBITS  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [GAP_W-1:0] gapCfg,
  output cpltStrobe_t      strb
);

  localparam int PULSES = 2 * NBITS + 2;
  localparam int PW     = $clog2(PULSES + 1);
  localparam int DW     = (DIV > 1) ? $clog2(DIV) : 1;

  cpltState_t       state;
  logic [DW-1:0]    divCnt;
  logic [PW-1:0]    pulseIdx;
  logic [PW-1:0]    nextIdx;
  logic [GAP_W-1:0] gapLeft;
  logic             accept;
  logic             tick;
  logic             lastPulse;

  assign inReady   = (state == ST_IDLE);
  assign accept    = inValid && inReady;
  assign tick      = (divCnt == DW'(DIV - 1));
  assign nextIdx   = pulseIdx + 1'b1;
  assign lastPulse = (pulseIdx == PW'(PULSES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      pulseIdx <= '0;
      gapLeft  <= '0;
    end else if (accept) begin
      state    <= ST_SEND;
      divCnt   <= '0;
      pulseIdx <= '0;
      gapLeft  <= gapCfg;
    end else if (state != ST_IDLE) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        if (state == ST_SEND) begin
          if (lastPulse) begin
            pulseIdx <= '0;
            state    <= (gapLeft == '0) ? ST_IDLE : ST_GAP;
          end else begin
            pulseIdx <= nextIdx;
          end
        end else begin
          gapLeft <= gapLeft - 1'b1;
          if (gapLeft == GAP_W'(1)) state <= ST_IDLE;
        end
      end
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.emitPre = accept;
    if (state == ST_SEND && tick) begin
      if (lastPulse)                        strb.emitIdle  = 1'b1;
      else if (nextIdx == PW'(PULSES - 1))  strb.emitPost  = 1'b1;
      else if (nextIdx[0])                  strb.emitTrue  = 1'b1;
      else                                  strb.emitCompl = 1'b1;
    end
  end

endmodule

// File: rtl/cplt_dp.sv
module cplt_dp
  import cplt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NBITS  = DATA_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cpltStrobe_t       strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSof,
  input  logic              inBerr,
  output logic              txPos,
  output logic              txNeg
);

  // Frame order, LSB leaves first: sync, sync, SOF, data LSB..MSB, error flag.
  logic [NBITS-1:0] frame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frame <= '0;
      txPos <= 1'b0;
      txNeg <= 1'b0;
    end else begin
      if (strb.load) frame <= {inBerr, inData, inSof, 2'b00};
      if (strb.emitPre) begin
        txPos <= 1'b1;
        txNeg <= 1'b0;
      end else if (strb.emitTrue) begin
        txPos <= frame[0];
        txNeg <= ~frame[0];
      end else if (strb.emitCompl) begin
        txPos <= ~frame[0];
        txNeg <= frame[0];
        frame <= frame >> 1;
      end else if (strb.emitPost) begin
        txPos <= 1'b0;
        txNeg <= 1'b1;
      end else if (strb.emitIdle) begin
        txPos <= 1'b0;
        txNeg <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cplt_ser.sv
module cplt_ser
  import cplt_pkg::*;
#(
  parameter int CLK_HZ   = 32_000_000,
  parameter int PULSE_HZ = 4_000_000,
  parameter int DATA_W   = 8,
  parameter int GAP_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSof,
  input  logic              inBerr,
  input  logic [GAP_W-1:0]  gapCfg,
  output logic              txPos,
  output logic              txNeg
);

  localparam int DIV   = CLK_HZ / PULSE_HZ;
  localparam int NBITS = DATA_W + 4;

  cpltStrobe_t strb;

  cplt_ctrl #(.DIV(DIV), .GAP_W(GAP_W), .NBITS(NBITS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .gapCfg  (gapCfg),
    .strb    (strb)
  );

  cplt_dp #(.DATA_W(DATA_W), .NBITS(NBITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .inData (inData),
    .inSof  (inSof),
    .inBerr (inBerr),
    .txPos  (txPos),
    .txNeg  (txNeg)
  );

endmodule

// File: rtl/cplt_ser_chk.sv
module cplt_ser_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic txPos,
  input logic txNeg
);

  // R10
  legs_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txPos && txNeg));

  // R1
  ready_line_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!txPos && !txNeg));

  // R3
  accept_preamble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (txPos && !txNeg && !inReady));

  // R2
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inReady) |-> $past(inValid));

endmodule

bind cplt_ser cplt_ser_chk u_cplt_ser_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .txPos   (txPos),
  .txNeg   (txNeg)
);

// File: tb/cplt_ser_bench.sv
module cplt_ser_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 8;
  localparam int PULSES     = 26;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic       inReady;
  logic [7:0] inData;
  logic       inSof;
  logic       inBerr;
  logic [7:0] gapCfg;
  logic       txPos;
  logic       txNeg;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cplt_ser u_cplt_ser (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSof(inSof), .inBerr(inBerr), .gapCfg(gapCfg),
    .txPos(txPos), .txNeg(txNeg)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Expected legs at cycle offset c after acceptance.
  function automatic logic expPos(input int c, input logic [11:0] fr);
    int n = c / DIV;
    if (n == 0) return 1'b1;
    if (n <= 24) return ((n - 1) % 2 == 0) ? fr[(n - 1) / 2] : ~fr[(n - 1) / 2];
    return 1'b0;
  endfunction

  function automatic logic expNeg(input int c, input logic [11:0] fr);
    int n = c / DIV;
    if (n == 0) return 1'b0;
    if (n <= 24) return ((n - 1) % 2 == 0) ? ~fr[(n - 1) / 2] : fr[(n - 1) / 2];
    if (n == 25) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string tagOf(input int c);
    int n = c / DIV;
    if (n == 0) return "R3 R4";
    if (n <= 24) return "R4 R5 R6";
    if (n == 25) return "R7";
    if (n == 26) return "R8";
    return "R9";
  endfunction

  // Starts and ends at a negedge with inReady high.
  task automatic sendByte(input logic [7:0] d, input logic sof, input logic berr,
                          input logic [7:0] gap, input bit junk);
    logic [11:0] fr;
    int total;
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = d; inSof = sof; inBerr = berr; gapCfg = gap;
    @(posedge clk);
    @(negedge clk);
    fr    = {berr, d, sof, 2'b00};
    total = (PULSES + int'(gap)) * DIV;
    for (int c = 0; c <= total; c++) begin
      if (junk && c < total) begin
        inValid = 1'b1; inData = 8'($urandom); inSof = 1'($urandom);
        inBerr = 1'($urandom); gapCfg = 8'($urandom);
      end else begin
        inValid = 1'b0;
      end
      chk(tagOf(c), txPos, expPos(c, fr));
      chk(tagOf(c), txNeg, expNeg(c, fr));
      chk("R10", txPos & txNeg, 1'b0);
      if (c < total) chk("R2", inReady, 1'b0);
      else           chk("R9", inReady, 1'b1);
      if (c < total) @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nBad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; inValid = 1'b0; inData = '0; inSof = 1'b0; inBerr = 1'b0; gapCfg = '0;
    repeat (3) @(negedge clk);
    chk("R1", txPos, 1'b0);
    chk("R1", txNeg, 1'b0);
    chk("R1", inReady, 1'b1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", inReady, 1'b1);
    chk("R1", txPos | txNeg, 1'b0);

    // Directed corners
    sendByte(8'h00, 1'b0, 1'b0, 8'd0, 1'b0);
    sendByte(8'hFF, 1'b1, 1'b1, 8'd3, 1'b0);
    sendByte(8'hA5, 1'b1, 1'b0, 8'd1, 1'b1);
    sendByte(8'h01, 1'b0, 1'b1, 8'd0, 1'b1);
    sendByte(8'h80, 1'b0, 1'b0, 8'd2, 1'b1);

    // Idle stretch with no offer: line stays quiet, ready stays high
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R9", inReady, 1'b1);
      chk("R10", txPos | txNeg, 1'b0);
    end

    // Constrained random
    for (int i = 0; i < 24; i++)
      sendByte(8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom % 4), 1'($urandom));

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule